// File: doc/BRIEF.md
# Toggle-Status Interrupt Router

This block keeps a 32-bit interrupt status word in which each bit stands for one internal interrupt source. Hardware event lines set status bits. Software flips status bits through a small register bus, where a written 1 inverts the bit and a written 0 leaves it alone. There is no separate mask. Two of the sources, at status bits 16 and 17, each have a routing register that names one hardware thread of a multi-threaded core. When the status bit of such a source goes from 0 to 1, the router raises that thread's trigger line.

Each thread has one active-low, level-style trigger output. A trigger stays low until software writes an acknowledge for that thread. All routed sources aimed at the same thread share its line. Software disables a source by writing zero to its routing register. Software can re-raise an interrupt by toggling its status bit to 0 and then back to 1.

Register map (word addresses on `bus_addr`): 0 = status, 1 = routing register for bit 16, 2 = routing register for bit 17, 3 = thread acknowledge (write only). All other addresses are unmapped.

Top module: `irq_router`

## Requirements
- R1: After reset, all status bits and both routing registers read as 0, and every bit of `trig_n` is 1.
- R2: A write to address 0 inverts each status bit whose `bus_wdata` bit is 1 and leaves each bit whose `bus_wdata` bit is 0 unchanged. The change is visible from the next clock edge.
- R3: A 1 on `hw_evt[i]` makes status bit i equal 1 after the clock edge, whatever its previous value. When the same bit is toggled by software and set by hardware in one cycle, the result is 1.
- R4: When status bit 16 (routed by address 1) or status bit 17 (routed by address 2) changes from 0 to 1, and its routing register holds a value v with 1 ≤ v ≤ 4, `trig_n[v-1]` goes low at the same clock edge that updates the status bit. Either a hardware event or a software toggle can cause the change.
- R5: A routed status bit that goes from 1 to 0, or that stays at 1 (for example, a hardware event on an already-set bit), produces no trigger.
- R6: A routing register that holds 0, or a value above 4, sends its source's transitions to no thread. Routing registers store `bus_wdata[2:0]` and read back zero-extended.
- R7: Status bits other than 16 and 17 never produce a trigger.
- R8: A low `trig_n[t]` stays low until a write to address 3 with `bus_wdata[t]` = 1, which drives it high at the next edge. If a new rising source aimed at t arrives in the same cycle as that acknowledge, the line stays low.
- R9: Each source drives only the one thread its routing register names. When both sources name the same thread, that thread's trigger is their OR. When they name different threads, both lines go low.
- R10: When `bus_rd` is 1, `bus_rdata` takes, at the next edge, the value that the addressed register held in that cycle. Reads of address 3 or of unmapped addresses return 0. When `bus_rd` is 0, `bus_rdata` holds its value.
- R11: Writes to unmapped addresses (4 to 15) change neither the status bits, nor the routing registers, nor the trigger outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hw_evt | input | 32 | Hardware set request, one per status bit |
| trig_n | output | 4 | Per-thread trigger, active low |

## Verification
The bench targets the edges of the toggle rule. These cases are: a hardware set that collides with a software toggle on a bit already at 1, which a design giving set no priority would clear; a hardware event on a routed bit that is already set, which an edge-blind design would turn into a new trigger; and a falling routed bit, which must not fire. It checks an acknowledge that arrives in the same cycle as a new rise, where a design giving the clear priority would drop the interrupt. It also checks routing values of 0 and above the thread count, which a loosely decoded design would send to a thread. A third group covers both sources aimed at one thread and then at two different threads, and writes to unmapped addresses, which a partially decoded design would alias onto status or routing.

// File: rtl/irq_router_pkg.sv
// Package irq_router_pkg
// Shared types and helpers for the toggle-status interrupt router.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package irq_router_pkg;

    // Which register a bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_ACK  = 2'd3
    } reg_sel_e;

    // Width of a routing register: encodes 0 (off) plus one code per thread.
    function automatic int vec_width(input int n_threads);
        return $clog2(n_threads + 1);
    endfunction

    // Width of an index over the routed sources (at least one bit).
    function automatic int idx_width(input int n_routed);
        return (n_routed > 1) ? $clog2(n_routed) : 1;
    endfunction

endpackage

// File: rtl/irq_reg_dec.sv
// Module irq_reg_dec
// Decodes the word address into a register select and per-register write
// enables. Map: 0 status, 1..N_ROUTED routing registers, N_ROUTED+1 ack.
// Assumes: ADDR_W is wide enough to hold N_ROUTED+1.
module irq_reg_dec
    import irq_router_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int N_ROUTED = 2,
    parameter int IDX_W    = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output reg_sel_e            sel,
    output logic [IDX_W-1:0]    vec_idx,
    output logic                stat_we,
    output logic [N_ROUTED-1:0] vec_we,
    output logic                ack_we
);

    localparam logic [ADDR_W-1:0] ADDR_STAT = '0;
    localparam logic [ADDR_W-1:0] ADDR_ACK  = ADDR_W'(N_ROUTED + 1);

    // Select the addressed register; unmapped addresses select nothing.
    always_comb begin
        sel     = SEL_NONE;
        vec_idx = '0;
        if (addr == ADDR_STAT) begin
            sel = SEL_STAT;
        end else if (addr == ADDR_ACK) begin
            sel = SEL_ACK;
        end
        for (int r = 0; r < N_ROUTED; r++) begin
            if (addr == ADDR_W'(r + 1)) begin
                sel     = SEL_VEC;
                vec_idx = IDX_W'(r);
            end
        end
    end

    assign stat_we = wr && (sel == SEL_STAT);
    assign ack_we  = wr && (sel == SEL_ACK);

    // One write enable per routing register.
    for (genvar r = 0; r < N_ROUTED; r++) begin : g_vec_we
        assign vec_we[r] = wr && (sel == SEL_VEC) && (vec_idx == IDX_W'(r));
    end

endmodule

// File: rtl/irq_stat_reg.sv
// Module irq_stat_reg
// Holds the interrupt status word. Software toggles bits (1 inverts, 0
// keeps); hardware events force bits to 1, winning over a same-cycle toggle.
// Reports 0->1 transitions of the routed bits for the cycle being committed.
// Assumes: ROUTED_BASE + N_ROUTED <= STAT_W.
module irq_stat_reg #(
    parameter int STAT_W      = 32,
    parameter int ROUTED_BASE = 16,
    parameter int N_ROUTED    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tog_we,
    input  logic [STAT_W-1:0]   tog_bits,
    input  logic [STAT_W-1:0]   hw_evt,
    output logic [STAT_W-1:0]   stat_q,
    output logic [N_ROUTED-1:0] rise_routed
);

    logic [STAT_W-1:0] tog_mask;
    logic [STAT_W-1:0] stat_d;

    // Next status: apply the toggle, then let hardware sets dominate.
    always_comb begin
        tog_mask = tog_we ? tog_bits : '0;
        stat_d   = (stat_q ^ tog_mask) | hw_evt;
    end

    // Rising edges of the routed bits between current and next status.
    assign rise_routed = stat_d[ROUTED_BASE +: N_ROUTED] & ~stat_q[ROUTED_BASE +: N_ROUTED];

    // Status register with synchronous reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

endmodule

// File: rtl/irq_vec_bank.sv
// Module irq_vec_bank
// One routing register per routed source. A value v in 1..N_THREADS sends the
// source to thread v-1; 0 (or any larger code) disables the source.
// Assumes: write data is already narrowed to VEC_W bits.
module irq_vec_bank #(
    parameter int N_ROUTED = 2,
    parameter int VEC_W    = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_ROUTED-1:0]             vec_we,
    input  logic [VEC_W-1:0]                wdata,
    output logic [N_ROUTED-1:0][VEC_W-1:0]  vec_q
);

    for (genvar r = 0; r < N_ROUTED; r++) begin : g_vec
        // Routing register r: reset to off, load on its own write enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[r] <= '0;
            end else if (vec_we[r]) begin
                vec_q[r] <= wdata;
            end
        end
    end

endmodule

// File: rtl/irq_trig_gen.sv
// Module irq_trig_gen
// Turns routed rising edges into per-thread pending flags and drives the
// active-low trigger lines. A flag clears only on an acknowledge write; a
// same-cycle new rise takes priority over the acknowledge.
// Assumes: rise inputs are single-cycle indications from the status register.
module irq_trig_gen #(
    parameter int N_ROUTED  = 2,
    parameter int N_THREADS = 4,
    parameter int VEC_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_ROUTED-1:0]             rise,
    input  logic [N_ROUTED-1:0][VEC_W-1:0]  vec_q,
    input  logic                            ack_we,
    input  logic [N_THREADS-1:0]            ack_bits,
    output logic [N_THREADS-1:0]            trig_n
);

    logic [N_ROUTED-1:0][N_THREADS-1:0] hit;
    logic [N_THREADS-1:0]               set_bits;
    logic [N_THREADS-1:0]               clr_bits;
    logic [N_THREADS-1:0]               pend_q;

    // Decode each source's routing code into at most one thread hit.
    for (genvar r = 0; r < N_ROUTED; r++) begin : g_src
        for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
            assign hit[r][t] = rise[r] && (vec_q[r] == VEC_W'(t + 1));
        end
    end

    // Merge the hits of all sources aimed at a thread.
    always_comb begin
        set_bits = '0;
        for (int r = 0; r < N_ROUTED; r++) begin
            set_bits = set_bits | hit[r];
        end
        clr_bits = ack_we ? ack_bits : '0;
    end

    // Pending flags: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_bits) | set_bits;
        end
    end

    assign trig_n = ~pend_q;

endmodule

// File: rtl/irq_router.sv
// Module irq_router (top)
// Toggle-status interrupt router: status word, routing registers for the
// routed sources and per-thread active-low trigger lines, behind a simple
// read/write register bus with one cycle of read latency.
// Assumes: STAT_W >= max(N_THREADS, VEC_W); ADDR_W holds N_ROUTED+1.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int STAT_W      = 32,
    parameter int N_THREADS   = 4,
    parameter int N_ROUTED    = 2,
    parameter int ROUTED_BASE = 16,
    parameter int ADDR_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [STAT_W-1:0]    bus_wdata,
    output logic [STAT_W-1:0]    bus_rdata,
    input  logic [STAT_W-1:0]    hw_evt,
    output logic [N_THREADS-1:0] trig_n
);

    localparam int VEC_W = vec_width(N_THREADS);
    localparam int IDX_W = idx_width(N_ROUTED);

    reg_sel_e                         sel;
    logic [IDX_W-1:0]                 vec_idx;
    logic                             stat_we;
    logic [N_ROUTED-1:0]              vec_we;
    logic                             ack_we;
    logic [STAT_W-1:0]                stat_q;
    logic [N_ROUTED-1:0]              rise_routed;
    logic [N_ROUTED-1:0][VEC_W-1:0]   vec_q;
    logic [STAT_W-1:0]                rd_val;

    irq_reg_dec #(
        .ADDR_W   (ADDR_W),
        .N_ROUTED (N_ROUTED),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .sel     (sel),
        .vec_idx (vec_idx),
        .stat_we (stat_we),
        .vec_we  (vec_we),
        .ack_we  (ack_we)
    );

    irq_stat_reg #(
        .STAT_W      (STAT_W),
        .ROUTED_BASE (ROUTED_BASE),
        .N_ROUTED    (N_ROUTED)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .tog_we      (stat_we),
        .tog_bits    (bus_wdata),
        .hw_evt      (hw_evt),
        .stat_q      (stat_q),
        .rise_routed (rise_routed)
    );

    irq_vec_bank #(
        .N_ROUTED (N_ROUTED),
        .VEC_W    (VEC_W)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_we (vec_we),
        .wdata  (bus_wdata[VEC_W-1:0]),
        .vec_q  (vec_q)
    );

    irq_trig_gen #(
        .N_ROUTED  (N_ROUTED),
        .N_THREADS (N_THREADS),
        .VEC_W     (VEC_W)
    ) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_routed),
        .vec_q    (vec_q),
        .ack_we   (ack_we),
        .ack_bits (bus_wdata[N_THREADS-1:0]),
        .trig_n   (trig_n)
    );

    // Read mux over the current register values.
    always_comb begin
        case (sel)
            SEL_STAT: rd_val = stat_q;
            SEL_VEC:  rd_val = STAT_W'(vec_q[vec_idx]);
            default:  rd_val = '0;
        endcase
    end

    // Registered read data: loads on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

endmodule

// File: rtl/irq_router_chk.sv
// Module irq_router_chk
// Property checker for irq_router, attached by bind. Observes the bus, the
// event inputs, the status register and the trigger lines.
// Assumes: same parameter values as the bound instance.
module irq_router_chk #(
    parameter int STAT_W      = 32,
    parameter int N_THREADS   = 4,
    parameter int N_ROUTED    = 2,
    parameter int ROUTED_BASE = 16,
    parameter int ADDR_W      = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [STAT_W-1:0]    bus_wdata,
    input logic [STAT_W-1:0]    hw_evt,
    input logic [STAT_W-1:0]    stat_q,
    input logic [N_THREADS-1:0] trig_n
);

    logic                 stat_wr;
    logic [N_THREADS-1:0] ack_mask;

    // Bus-side view of status writes and acknowledges.
    always_comb begin
        stat_wr  = bus_wr && (bus_addr == '0);
        ack_mask = (bus_wr && (bus_addr == ADDR_W'(N_ROUTED + 1))) ? bus_wdata[N_THREADS-1:0] : '0;
    end

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && (hw_evt == '0)) |=> (stat_q == ($past(stat_q) ^ $past(bus_wdata))));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && (hw_evt == '0)) |=> $stable(stat_q));

    assert_hw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((stat_q & $past(hw_evt)) == $past(hw_evt)));

    assert_trig_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~trig_n & $past(trig_n))) |->
        (|(stat_q[ROUTED_BASE +: N_ROUTED] & ~$past(stat_q[ROUTED_BASE +: N_ROUTED]))));

    assert_trig_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~trig_n & ~ack_mask)) |=>
        (((~trig_n) & $past(~trig_n & ~ack_mask)) == $past(~trig_n & ~ack_mask)));

endmodule

bind irq_router irq_router_chk #(
    .STAT_W      (STAT_W),
    .N_THREADS   (N_THREADS),
    .N_ROUTED    (N_ROUTED),
    .ROUTED_BASE (ROUTED_BASE),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .hw_evt    (hw_evt),
    .stat_q    (stat_q),
    .trig_n    (trig_n)
);

// File: tb/irq_router_test.sv
// Bench for irq_router: directed corner cases, then seeded random traffic,
// all compared against a cycle model built from the requirements.
module irq_router_test;

    localparam logic [3:0] A_STAT = 4'd0;
    localparam logic [3:0] A_VEC0 = 4'd1;
    localparam logic [3:0] A_VEC1 = 4'd2;
    localparam logic [3:0] A_ACK  = 4'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] evt = '0;
    logic [31:0] rdata;
    logic [3:0]  trig_n;

    int n_chk = 0;
    int n_fail = 0;

    // Model state
    logic [31:0] m_st = '0;
    logic [2:0]  m_vec0 = '0;
    logic [2:0]  m_vec1 = '0;
    logic [3:0]  m_pend = '0;
    logic [31:0] m_rdata = '0;

    always #10 clk = ~clk;

    irq_router uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .hw_evt    (evt),
        .trig_n    (trig_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Thread bit set by a routing code, or nothing if the code routes nowhere.
    function automatic logic [3:0] route(input logic rose, input logic [2:0] v);
        logic [3:0] b = '0;
        if (rose && v >= 3'd1 && v <= 3'd4) b[v - 3'd1] = 1'b1;
        return b;
    endfunction

    // Model one clock edge with the inputs currently applied.
    task automatic model_step();
        logic [31:0] tog, nst, rise;
        logic [3:0]  ack, setb;
        tog  = (wr && addr == A_STAT) ? wdata : '0;
        nst  = (m_st ^ tog) | evt;
        rise = nst & ~m_st;
        setb = route(rise[16], m_vec0) | route(rise[17], m_vec1);
        ack  = (wr && addr == A_ACK) ? wdata[3:0] : '0;
        if (rd) begin
            case (addr)
                A_STAT:  m_rdata = m_st;
                A_VEC0:  m_rdata = {29'b0, m_vec0};
                A_VEC1:  m_rdata = {29'b0, m_vec1};
                default: m_rdata = '0;
            endcase
        end
        m_pend = (m_pend & ~ack) | setb;
        if (wr && addr == A_VEC0) m_vec0 = wdata[2:0];
        if (wr && addr == A_VEC1) m_vec1 = wdata[2:0];
        m_st = nst;
    endtask

    // One bus cycle: drive at the falling edge, check after the rising edge.
    task automatic cyc(input logic [3:0] a, input logic w, input logic r,
                       input logic [31:0] d, input logic [31:0] e);
        addr = a; wr = w; rd = r; wdata = d; evt = e;
        @(posedge clk);
        model_step();
        #5;
        chk("R8 trigger vs model", {28'b0, trig_n}, {28'b0, ~m_pend});
        chk("R10 read data vs model", rdata, m_rdata);
        @(negedge clk);
        addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; evt = '0;
    endtask

    task automatic idle();
        cyc(A_STAT, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d);
        cyc(a, 1'b1, 1'b0, d, '0);
    endtask

    task automatic rreg(input logic [3:0] a);
        cyc(a, 1'b0, 1'b1, '0, '0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 trig_n after reset", {28'b0, trig_n}, 32'hF);
        rreg(A_STAT); chk("R1 status after reset", rdata, 32'h0);
        rreg(A_VEC0); chk("R1 route0 after reset", rdata, 32'h0);
        rreg(A_VEC1); chk("R1 route1 after reset", rdata, 32'h0);

        // R2: toggle semantics
        wreg(A_STAT, 32'h0000_00A5); rreg(A_STAT); chk("R2 toggle on", rdata, 32'h0000_00A5);
        wreg(A_STAT, 32'h0000_0005); rreg(A_STAT); chk("R2 toggle off", rdata, 32'h0000_00A0);
        wreg(A_STAT, 32'h0);         rreg(A_STAT); chk("R2 zero write keeps", rdata, 32'h0000_00A0);

        // R3: hardware set, repeated set, set colliding with toggle
        cyc(A_STAT, 1'b0, 1'b0, '0, 32'h8); rreg(A_STAT); chk("R3 hw set", rdata, 32'h0000_00A8);
        cyc(A_STAT, 1'b0, 1'b0, '0, 32'h8); rreg(A_STAT); chk("R3 hw set on 1", rdata, 32'h0000_00A8);
        cyc(A_STAT, 1'b1, 1'b0, 32'h80, 32'h80); rreg(A_STAT); chk("R3 set beats toggle", rdata, 32'h0000_00A8);

        // R10: one-cycle latency and hold without a read strobe
        wreg(A_STAT, 32'h1); rreg(A_STAT); chk("R10 read value", rdata, 32'h0000_00A9);
        wreg(A_STAT, 32'h1); chk("R10 rdata holds", rdata, 32'h0000_00A9);
        rreg(A_ACK); chk("R10 ack reads zero", rdata, 32'h0);
        wreg(A_STAT, 32'h0000_00A8);

        // R4: routed rise by software toggle reaches thread 1
        wreg(A_VEC0, 32'h2); rreg(A_VEC0); chk("R6 route readback", rdata, 32'h2);
        wreg(A_STAT, 32'h0001_0000); chk("R4 toggle rise to thread1", {28'b0, trig_n}, 32'hD);

        // R8: hold until the matching acknowledge
        idle(); idle(); idle(); chk("R8 held low", {28'b0, trig_n}, 32'hD);
        wreg(A_ACK, 32'h1); chk("R8 other ack ignored", {28'b0, trig_n}, 32'hD);
        wreg(A_ACK, 32'h2); chk("R8 ack releases", {28'b0, trig_n}, 32'hF);

        // R5: falling edge and set-on-set do not fire; hw rise does (R4)
        wreg(A_STAT, 32'h0001_0000); chk("R5 fall no trigger", {28'b0, trig_n}, 32'hF);
        cyc(A_STAT, 1'b0, 1'b0, '0, 32'h0001_0000); chk("R4 hw rise fires", {28'b0, trig_n}, 32'hD);
        wreg(A_ACK, 32'h2);
        cyc(A_STAT, 1'b0, 1'b0, '0, 32'h0001_0000); chk("R5 set on set no trigger", {28'b0, trig_n}, 32'hF);

        // R8: new rise in the acknowledge cycle keeps the line low
        wreg(A_STAT, 32'h0001_0000);
        cyc(A_STAT, 1'b0, 1'b0, '0, 32'h0001_0000);
        wreg(A_STAT, 32'h0001_0000);
        cyc(A_ACK, 1'b1, 1'b0, 32'h2, 32'h0001_0000); chk("R8 rise beats ack", {28'b0, trig_n}, 32'hD);
        wreg(A_ACK, 32'h2); chk("R8 released", {28'b0, trig_n}, 32'hF);

        // R6: routing code 0 and out-of-range code route nowhere
        wreg(A_VEC0, 32'h0);
        wreg(A_STAT, 32'h0001_0000); wreg(A_STAT, 32'h0001_0000);
        chk("R6 code zero silent", {28'b0, trig_n}, 32'hF);
        wreg(A_VEC0, 32'h5);
        wreg(A_STAT, 32'h0001_0000); wreg(A_STAT, 32'h0001_0000);
        chk("R6 code above threads silent", {28'b0, trig_n}, 32'hF);

        // R9: both sources to one thread, then to two threads
        wreg(A_VEC0, 32'h3); wreg(A_VEC1, 32'h3);
        wreg(A_STAT, 32'h0001_0000);
        wreg(A_STAT, 32'h0003_0000); chk("R9 shared thread", {28'b0, trig_n}, 32'hB);
        wreg(A_ACK, 32'h4);
        wreg(A_VEC0, 32'h1); wreg(A_VEC1, 32'h4);
        wreg(A_STAT, 32'h0003_0000);
        wreg(A_STAT, 32'h0003_0000); chk("R9 two threads", {28'b0, trig_n}, 32'h6);
        wreg(A_ACK, 32'h9); chk("R9 both released", {28'b0, trig_n}, 32'hF);

        // R7: all unrouted bits rise, no trigger
        wreg(A_STAT, 32'hFFFC_FFFF); chk("R7 unrouted silent", {28'b0, trig_n}, 32'hF);
        rreg(A_STAT); chk("R7 status all set", rdata, 32'hFFFF_FFFF);

        // R11: unmapped writes change nothing
        wreg(4'd5, 32'hFFFF_FFFF); wreg(4'd15, 32'h0003_0003);
        chk("R11 trig unchanged", {28'b0, trig_n}, 32'hF);
        rreg(A_STAT); chk("R11 status unchanged", rdata, 32'hFFFF_FFFF);
        rreg(A_VEC0); chk("R11 route0 unchanged", rdata, 32'h1);
        rreg(A_VEC1); chk("R11 route1 unchanged", rdata, 32'h4);

        // Random traffic against the model (R2, R3, R4, R8, R10 under mixes)
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  a;
            logic [31:0] d, e;
            case ($urandom % 6)
                0, 5:    a = A_STAT;
                1:       a = A_VEC0;
                2:       a = A_VEC1;
                3:       a = A_ACK;
                default: a = 4'd5 + 4'($urandom % 11);
            endcase
            d = (a == A_STAT && ($urandom % 2 == 0)) ? ($urandom & 32'h0003_0000) : $urandom;
            e = ($urandom % 4 == 0) ? ((32'h1 << ($urandom % 32)) | ($urandom & 32'h0003_0000)) : 32'h0;
            cyc(a, 1'($urandom % 2), 1'($urandom % 2), d, e);
        end

        finish_run();
    end

endmodule